// File: doc/BRIEF.md
# Floating-Point Min/Max Unit

This unit picks the smaller or the larger of two floating-point operands in single (32-bit) or double (64-bit) precision. The result is purely combinational from the operand, precision and operation inputs. A registered, sticky exception status vector collects an invalid-operation indication across every operation that is strobed in with the valid input. The vector stays set until a dedicated clear input wipes it.

NaN handling differs from plain IEEE propagation. If one operand is a NaN, the unit returns the other operand. If both are NaNs, it returns an all-ones pattern. Only signalling NaNs raise the invalid flag. Quiet NaNs pass silently. Ordering of ordinary numbers, including infinities and signed zeros, follows sign and magnitude. The unit is meant to sit beside an FP register file as the min/max lane of an execute stage.

Top module: `fp_minmax`

## Requirements
- R1: When exactly one operand is a NaN (exponent all ones, mantissa nonzero), `result` equals the other operand unchanged, for both min (`sel_max`=0) and max (`sel_max`=1).
- R2: When both operands are NaNs, `result` is all ones over the selected width: 64'hFFFFFFFF_FFFFFFFF in double mode and 64'h00000000_FFFFFFFF in single mode.
- R3: A NaN is signalling when its top mantissa bit (bit 51 in double, bit 22 in single) is zero. Any operation with `in_valid`=1 that has at least one signalling NaN operand sets `flags[1]` (invalid) at the next clock edge, in either precision.
- R4: An operation whose NaN operands are all quiet (top mantissa bit one) does not set `flags[1]`, whether one or both operands are NaN.
- R5: For non-NaN operands, the result follows sign-magnitude ordering, with infinities at the extremes and -0 ordered below +0. So min(-0,+0) = -0 and max(-0,+0) = +0.
- R6: The flags are sticky. Each valid operation ORs its indication into them. They do not change when `in_valid` is low, and they persist across later operations that raise nothing.
- R7: `flag_clr`=1 clears `flags` to zero at the next clock edge. It takes priority over an operation strobed in the same cycle.
- R8: In single mode (`dbl`=0), only bits 31:0 of each operand are used, and `result[63:32]` is zero.
- R9: After reset `flags` is zero. Bits 0, 2, 3, 4 and 5 of `flags` (divide-by-zero is bit 2, overflow bit 3, underflow bit 4, inexact bit 5) always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: the current operation updates the flags |
| op_a | input | 64 | First operand (low 32 bits in single mode) |
| op_b | input | 64 | Second operand (low 32 bits in single mode) |
| dbl | input | 1 | 1 = double precision, 0 = single precision |
| sel_max | input | 1 | 1 = maximum, 0 = minimum |
| flag_clr | input | 1 | Clears the sticky flags |
| result | output | 64 | Selected value, combinational |
| flags | output | 6 | Sticky status: bit 1 invalid, other bits zero |

## Verification
A wrong NaN classification shows up at once on `result` in the same cycle. The same fault also shows one cycle later as a missing or spurious invalid bit, which then persists until the next clear. That persistence means a single bad flag update stays visible at every later sample. The bench therefore checks the flags after each strobe, not only at the end. Ordering faults around signed zeros and infinities, and any leakage of upper operand bits in single mode, are visible combinationally on the very vector that triggers them.

// File: rtl/fp_minmax.sv
module fp_minmax (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic        dbl,
  input  logic        sel_max,
  input  logic        flag_clr,
  output logic [63:0] result,
  output logic [5:0]  flags
);
  localparam int INV_BIT = 1;

  logic [63:0] ea, eb;
  logic [62:0] mag_a, mag_b;
  logic        sgn_a, sgn_b;
  logic        nan_a, nan_b, snan_a, snan_b;
  logic        a_below_b, take_a;
  logic        flag_inv_q;

  assign ea = dbl ? op_a : {32'b0, op_a[31:0]};
  assign eb = dbl ? op_b : {32'b0, op_b[31:0]};

  assign sgn_a = dbl ? op_a[63] : op_a[31];
  assign sgn_b = dbl ? op_b[63] : op_b[31];
  assign mag_a = dbl ? op_a[62:0] : {32'b0, op_a[30:0]};
  assign mag_b = dbl ? op_b[62:0] : {32'b0, op_b[30:0]};

  assign nan_a = dbl ? (&op_a[62:52] && |op_a[51:0]) : (&op_a[30:23] && |op_a[22:0]);
  assign nan_b = dbl ? (&op_b[62:52] && |op_b[51:0]) : (&op_b[30:23] && |op_b[22:0]);
  assign snan_a = nan_a && !(dbl ? op_a[51] : op_a[22]);
  assign snan_b = nan_b && !(dbl ? op_b[51] : op_b[22]);

  assign a_below_b = (sgn_a != sgn_b) ? sgn_a
                   : (sgn_a ? (mag_a > mag_b) : (mag_a < mag_b));
  assign take_a = sel_max ? !a_below_b : a_below_b;

  always_comb begin
    if (nan_a && nan_b)
      result = dbl ? {64{1'b1}} : {32'b0, {32{1'b1}}};
    else if (nan_a)
      result = eb;
    else if (nan_b)
      result = ea;
    else
      result = take_a ? ea : eb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_inv_q <= 1'b0;
    else if (flag_clr)
      flag_inv_q <= 1'b0;
    else if (in_valid && (snan_a || snan_b))
      flag_inv_q <= 1'b1;
  end

  always_comb begin
    flags = '0;
    flags[INV_BIT] = flag_inv_q;
  end

  // R9: unused status bits stay clear
  a_r9_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] == 1'b0 && flags[5:2] == 4'b0);

  // R7: clear empties the vector on the next edge
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> flags == 6'b0);

  // R6: without clear, no set bit is lost
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((flags & $past(flags)) == $past(flags)));

  // R6: idle cycles leave the flags untouched
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !flag_clr) |=> $stable(flags));

  // R4: quiet-only operations never raise invalid
  a_r4_quiet_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flag_clr && !snan_a && !snan_b && !flags[INV_BIT]) |=> !flags[INV_BIT]);

  // R3: a signalling input always raises invalid
  a_r3_signal_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flag_clr && (snan_a || snan_b)) |=> flags[INV_BIT]);

  // R8: single mode keeps the upper half clear
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl |-> result[63:32] == 32'b0);

  // R1 R2 R5: the result is always an operand or the all-ones pattern
  a_r1_result_source: assert property (@(posedge clk) disable iff (!rst_n)
    (result == ea) || (result == eb) || (&result[31:0]));
endmodule

// File: tb/fp_minmax_test.sv
module fp_minmax_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        dbl = 1'b0;
  logic        sel_max = 1'b0;
  logic        flag_clr = 1'b0;
  logic [63:0] result;
  logic [5:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [5:0] exp_flags = '0;
  bit done = 0;

  typedef struct {
    bit          chk_res;
    logic [63:0] res;
    logic [5:0]  flg;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  fp_minmax uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .dbl(dbl), .sel_max(sel_max), .flag_clr(flag_clr), .result(result), .flags(flags)
  );

  localparam logic [63:0] D_SNAN = 64'h7FF7000000000000;
  localparam logic [63:0] D_QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] D_ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] D_ANY  = 64'h3F80000000000000;
  localparam logic [63:0] ONES   = 64'hFFFFFFFFFFFFFFFF;
  localparam logic [63:0] S_ONES = 64'h00000000FFFFFFFF;

  task automatic drive(input bit v, input bit d, input bit mx, input bit clr,
                       input logic [63:0] a, input logic [63:0] b,
                       input bit chk, input logic [63:0] er, input bit inv,
                       input string tag);
    item_t it;
    @(negedge clk);
    in_valid = v; dbl = d; sel_max = mx; flag_clr = clr; op_a = a; op_b = b;
    if (clr) exp_flags = '0;
    else if (v && inv) exp_flags[1] = 1'b1;
    it.chk_res = chk; it.res = er; it.flg = exp_flags; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        if (it.chk_res) begin
          checks++;
          if (result !== it.res) begin
            errors++;
            $display("FAIL %s result act=%h exp=%h", it.tag, result, it.res);
          end
        end
        checks++;
        if (flags !== it.flg) begin
          errors++;
          $display("FAIL %s flags act=%h exp=%h", it.tag, flags, it.flg);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (flags !== 6'b0) begin
      errors++;
      $display("FAIL R9 reset flags act=%h exp=%h", flags, 6'b0);
    end
    rst_n = 1'b1;

    drive(1,1,0,0, D_SNAN, D_ANY, 1, D_ANY, 1, "R1 R3 dmin snan");
    drive(0,1,0,1, 0, 0, 0, 0, 0, "R7 clear");
    drive(1,1,1,0, D_QNAN, D_ANY, 1, D_ANY, 0, "R1 R4 dmax qnan");
    drive(1,1,0,0, D_ANY, D_QNAN, 1, D_ANY, 0, "R1 R4 dmin qnan second");
    drive(1,1,0,0, D_QNAN, D_QNAN, 1, ONES, 0, "R2 R4 dmin both qnan");
    drive(1,1,1,0, D_SNAN, D_SNAN, 1, ONES, 1, "R2 R3 dmax both snan");
    drive(1,1,0,0, D_ONE, 64'h4000000000000000, 1, D_ONE, 0, "R6 sticky after clean op");
    drive(0,1,0,1, 0, 0, 0, 0, 0, "R7 clear");
    drive(1,0,0,0, 64'h7FC00000, 64'h3F800000, 1, 64'h3F800000, 0, "R1 R4 smin qnan");
    drive(1,0,1,0, 64'h7FC00000, 64'h7FC00000, 1, S_ONES, 0, "R2 R4 smax both qnan");
    drive(1,0,1,0, 64'h7F800001, 64'h3F800000, 1, 64'h3F800000, 1, "R3 smax snan");
    drive(1,0,0,0, 64'h3F800000, 64'h40000000, 1, 64'h3F800000, 0, "R6 R5 smin sticky");
    drive(0,0,0,1, 0, 0, 0, 0, 0, "R7 clear");
    drive(1,0,0,0, 64'h80000000, 64'h00000000, 1, 64'h80000000, 0, "R5 smin signed zero");
    drive(1,0,1,0, 64'h80000000, 64'h00000000, 1, 64'h00000000, 0, "R5 smax signed zero");
    drive(1,1,0,0, 64'h0, 64'h8000000000000000, 1, 64'h8000000000000000, 0, "R5 dmin signed zero");
    drive(1,1,1,0, 64'hBFF0000000000000, 64'hC000000000000000, 1, 64'hBFF0000000000000, 0, "R5 dmax negatives");
    drive(1,1,0,0, 64'hBFF0000000000000, 64'hC000000000000000, 1, 64'hC000000000000000, 0, "R5 dmin negatives");
    drive(1,0,1,0, 64'h7F800000, 64'h3F800000, 1, 64'h7F800000, 0, "R5 smax infinity");
    drive(1,0,0,0, 64'hFF800000, 64'hBF800000, 1, 64'hFF800000, 0, "R5 smin neg infinity");
    drive(1,0,1,0, 64'hDEADBEEF3F800000, 64'h1234567840000000, 1, 64'h40000000, 0, "R8 upper bits ignored");
    drive(1,0,0,0, 64'hFFFFFFFF7FC00000, 64'h00000000BF800000, 1, 64'hBF800000, 0, "R8 R1 upper bits ignored nan");
    drive(0,1,0,0, D_SNAN, D_SNAN, 0, 0, 0, "R6 idle ignores snan");
    drive(1,1,0,1, D_SNAN, D_ANY, 1, D_ANY, 0, "R7 clear wins over op");
    drive(1,0,0,0, 64'h00000001, 64'h346001D6, 1, 64'h00000001, 0, "R5 denormal order");
    drive(0,0,0,0, 0, 0, 0, 0, 0, "R9 idle tail");

    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule